// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block sits in the column path of an SDRAM controller. A mode-load strobe stores a mode word that holds the burst length, the wrap order, the read latency and a write-single-beat option. From then on, every read or write column command produces one column address per clock for the beats of its burst, together with a flag that marks the final beat. A separate strobe marks the clock cycles in which read data is expected back from the memory.

A command can be issued on every clock, and each one ends the burst before it. A stop strobe ends any burst, and it is the only way, apart from a new command, to end a full-page burst. Read beats that were already issued keep flowing through the latency pipeline after a stop. Mode words that use a reserved encoding are rejected and reported. Row and bank management, refresh and the pad interface are handled elsewhere.

Top module: `sdram_col_seq`

## Requirements
- R1: A mode load with a legal word updates the stored mode at that clock edge, and the new mode applies to the next command. Word bits: [2:0] burst length code (0=1, 1=2, 2=4, 3=8, 7=full page), [3] wrap order (0 sequential, 1 interleaved), [6:4] read latency in clocks (1..3), [7] single-beat writes (1 enables).
- R2: A mode word whose length code is 4, 5 or 6, whose latency field is 0 or above 3, or that combines full page with interleaved order leaves the stored mode unchanged. It also raises `mode_err` for exactly one cycle after the load edge.
- R3: In the cycle after a command is sampled, `col_valid` is high and `col_addr` equals the start column. After that, one beat is presented per clock.
- R4: With sequential order, beat k addresses the start column plus k, wrapped inside the block of burst-length columns that is aligned to the burst length and holds the start column.
- R5: With interleaved order, beat k addresses the start column with its low log2(burst length) bits XORed with k.
- R6: A burst of length 1, 2, 4 or 8 presents exactly that many beats. `col_last` is high on the final beat only, and `col_valid` drops in the following cycle unless a new command arrives.
- R7: A full-page burst steps through the columns sequentially and wraps from 255 to 0. It never raises `col_last` and continues until a stop or a new command.
- R8: A stop strobe without a command ends the current burst, so `col_valid` is low in the following cycle. A stop in the same cycle as a command has no effect, and a stop while idle has no effect.
- R9: A command sampled while a burst is active cuts that burst off. The next cycle already presents beat 0 of the new burst, even when commands arrive on consecutive clocks.
- R10: `rd_valid` is high exactly in the cycles that lie the programmed latency after a cycle that presented a read beat. This includes read beats of a burst that has since been stopped or interrupted.
- R11: With single-beat writes enabled, a write presents one beat with `col_last` high, and reads keep the programmed length. With the option off, writes use the programmed length. `col_write` marks the beats of a write.
- R12: After reset no burst is active, `rd_valid` and `mode_err` are low, and the mode is burst length 1, sequential, latency 2, single-beat writes off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Load `mode_word` into the mode register |
| mode_word | input | 8 | Mode word (layout in R1) |
| cmd_valid | input | 1 | Column command strobe |
| cmd_write | input | 1 | Command is a write (1) or a read (0) |
| cmd_col | input | COL_W (8) | Start column of the command |
| burst_stop | input | 1 | Ends the active burst |
| col_addr | output | COL_W (8) | Column address of the current beat, 0 when idle |
| col_valid | output | 1 | A beat is presented this cycle |
| col_last | output | 1 | Current beat is the final one |
| col_write | output | 1 | Current beat belongs to a write |
| rd_valid | output | 1 | Read data expected this cycle |
| mode_err | output | 1 | Previous mode load was rejected |

## Verification
Sequential bursts start from a column that is not aligned, so that the wrap inside the aligned block differs from a plain increment. The interleaved burst starts at an odd offset, so that the XOR order differs from the sequential order beat by beat. A full-page burst starts near the top of the column range, and running it past 300 beats shows both the wrap to zero and that no last flag appears. Commands on consecutive clocks, a stop issued together with a command, a stop while idle and a read cut off mid-burst separate the precedence rules from one another. Runs under each latency show that the data strobe follows the issued read beats rather than the burst length.

// File: rtl/col_seq_pkg.sv
package col_seq_pkg;

    localparam int MODE_W = 8;

    typedef enum logic [2:0] {
        BL_1    = 3'd0,
        BL_2    = 3'd1,
        BL_4    = 3'd2,
        BL_8    = 3'd3,
        BL_PAGE = 3'd7
    } blen_e;

    typedef struct packed {
        logic       single_wr;
        logic [1:0] cas_lat;
        logic       interleave;
        blen_e      blen;
    } mode_t;

    localparam mode_t MODE_RESET = '{single_wr: 1'b0, cas_lat: 2'd2,
                                     interleave: 1'b0, blen: BL_1};

    // Accepts only the encodings listed as legal for the mode word.
    function automatic logic mode_word_legal(input logic [MODE_W-1:0] w);
        logic len_ok;
        logic lat_ok;
        len_ok = (w[2:0] <= 3'd3) || (w[2:0] == 3'd7);
        lat_ok = (w[6:4] >= 3'd1) && (w[6:4] <= 3'd3);
        return len_ok && lat_ok && !((w[2:0] == 3'd7) && w[3]);
    endfunction

endpackage

// File: rtl/col_mode_reg.sv
module col_mode_reg
    import col_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] word,
    output mode_t             mode,
    output logic              err
);

    typedef struct packed {
        mode_t mode;
        logic  err;
    } state_t;

    state_t s_d, s_q;
    logic   legal;

    always_comb begin
        legal     = mode_word_legal(word);
        s_d       = s_q;
        s_d.err   = 1'b0;
        if (load) begin
            if (legal) begin
                s_d.mode.single_wr  = word[7];
                s_d.mode.cas_lat    = word[5:4];
                s_d.mode.interleave = word[3];
                s_d.mode.blen       = blen_e'(word[2:0]);
            end else begin
                s_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode <= MODE_RESET;
            s_q.err  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode = s_q.mode;
    assign err  = s_q.err;

    // R2: a rejected word leaves the stored mode untouched
    p_reserved_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !legal) |=> (mode == $past(mode)));

    // R1: a legal word is visible right after its load edge
    p_legal_loads_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load && legal) |=> (mode.cas_lat == $past(word[5:4]) &&
                             mode.single_wr == $past(word[7])));

endmodule

// File: rtl/col_burst_gen.sv
module col_burst_gen
    import col_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  blen_e            blen,
    input  logic             interleave,
    input  logic             single_wr,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             stop,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_last,
    output logic             col_write
);

    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    typedef struct packed {
        logic             active;
        logic             wr;
        logic             page;
        logic             inter;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] start;
        logic [COL_W-1:0] cnt;
    } state_t;

    state_t           s_d, s_q;
    logic [COL_W-1:0] len_mask;
    logic [COL_W-1:0] low_bits;
    logic             last_beat;

    always_comb begin
        unique case (blen)
            BL_1:    len_mask = COL_W'(0);
            BL_2:    len_mask = COL_W'(1);
            BL_4:    len_mask = COL_W'(3);
            BL_8:    len_mask = COL_W'(7);
            default: len_mask = '1;
        endcase

        last_beat = s_q.active && !s_q.page && (s_q.cnt == s_q.mask);
        low_bits  = s_q.inter ? (s_q.start ^ s_q.cnt) : (s_q.start + s_q.cnt);

        s_d = s_q;
        if (cmd_valid) begin
            s_d.active = 1'b1;
            s_d.wr     = cmd_write;
            s_d.inter  = interleave;
            s_d.start  = cmd_col;
            s_d.cnt    = '0;
            if (cmd_write && single_wr) begin
                s_d.mask = '0;
                s_d.page = 1'b0;
            end else begin
                s_d.mask = len_mask;
                s_d.page = (blen == BL_PAGE);
            end
        end else if (stop) begin
            s_d.active = 1'b0;
        end else if (s_q.active) begin
            if (last_beat) s_d.active = 1'b0;
            else           s_d.cnt    = s_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign col_valid = s_q.active;
    assign col_last  = last_beat;
    assign col_write = s_q.active && s_q.wr;
    assign col_addr  = s_q.active ? ((s_q.start & ~s_q.mask) | (low_bits & s_q.mask)) : '0;

    // R3: beat 0 of a burst is the start column, one cycle later
    p_first_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (col_valid && col_addr == $past(cmd_col)));

    // R6: nothing follows the final beat without a fresh command
    p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !cmd_valid) |=> !col_valid);

    // R8: a stop without a command ends the burst
    p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !cmd_valid) |=> !col_valid);

    // R11: a write in single-beat mode is its own last beat
    p_single_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_write && single_wr) |=> (col_last && col_write));

endmodule

// File: rtl/col_lat_pipe.sv
module col_lat_pipe #(
    parameter int MAX_CL = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cas_lat,
    input  logic       beat_in,
    output logic       rd_valid
);

    logic [MAX_CL-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[MAX_CL-2:0], beat_in};
        if (cas_lat != 2'd0 && int'(cas_lat) <= MAX_CL) rd_valid = sh_q[int'(cas_lat) - 1];
        else                                            rd_valid = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // R10: with latency 1 a read beat is followed by the data strobe
    p_lat1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_in && cas_lat == 2'd1) |=> (cas_lat != 2'd1 || rd_valid));

    // R10: no data strobe appears without a read beat latency cycles back
    p_lat2_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_lat == 2'd2 && $past(cas_lat) == 2'd2 && !$past(beat_in, 2)) |-> !rd_valid);

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
    import col_seq_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int MAX_CL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_load,
    input  logic [7:0]       mode_word,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             burst_stop,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_last,
    output logic             col_write,
    output logic             rd_valid,
    output logic             mode_err
);

    mode_t mode;

    col_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mode_load),
        .word  (mode_word),
        .mode  (mode),
        .err   (mode_err)
    );

    col_burst_gen #(.COL_W(COL_W)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .blen       (mode.blen),
        .interleave (mode.interleave),
        .single_wr  (mode.single_wr),
        .cmd_valid  (cmd_valid),
        .cmd_write  (cmd_write),
        .cmd_col    (cmd_col),
        .stop       (burst_stop),
        .col_addr   (col_addr),
        .col_valid  (col_valid),
        .col_last   (col_last),
        .col_write  (col_write)
    );

    col_lat_pipe #(.MAX_CL(MAX_CL)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .cas_lat  (mode.cas_lat),
        .beat_in  (col_valid && !col_write),
        .rd_valid (rd_valid)
    );

    // R12: the data strobe is never high without an issued beat behind it
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(col_valid) && !$past(col_valid, 2) && !$past(col_valid, 3)) |-> !rd_valid);

endmodule

// File: tb/sdram_col_seq_tb.sv
module sdram_col_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_load = 1'b0;
    logic [7:0] mode_word = '0;
    logic       cmd_valid = 1'b0;
    logic       cmd_write = 1'b0;
    logic [7:0] cmd_col = '0;
    logic       burst_stop = 1'b0;
    logic [7:0] col_addr;
    logic       col_valid, col_last, col_write, rd_valid, mode_err;

    always #2.5 clk = ~clk;

    sdram_col_seq u_dut (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_col(cmd_col),
        .burst_stop(burst_stop), .col_addr(col_addr), .col_valid(col_valid),
        .col_last(col_last), .col_write(col_write), .rd_valid(rd_valid),
        .mode_err(mode_err)
    );

    typedef struct {
        int col;
        bit last;
        bit wr;
    } beat_t;

    beat_t q[$];
    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R12";
    bit    run = 1'b0;
    bit    hist[1:3] = '{1'b0, 1'b0, 1'b0};

    // model of the mode register (R12 reset values)
    int m_beats = 1;
    bit m_page = 1'b0;
    bit m_inter = 1'b0;
    int m_cl = 2;
    bit m_single = 1'b0;

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // monitor: pops one expected beat per cycle
    always @(negedge clk) begin
        if (run) begin
            bit rd_now;
            rd_now = 1'b0;
            if (q.size() > 0) begin
                beat_t b;
                b = q.pop_front();
                check(cur_tag, int'(col_valid), 1, "col_valid");
                check(cur_tag, int'(col_addr), b.col, "col_addr");
                check(cur_tag, int'(col_last), int'(b.last), "col_last");
                check("R11", int'(col_write), int'(b.wr), "col_write");
                rd_now = !b.wr;
            end else begin
                check(cur_tag, int'(col_valid), 0, "col_valid idle");
            end
            check("R10", int'(rd_valid), int'(hist[m_cl]), "rd_valid");
            hist[3] = hist[2];
            hist[2] = hist[1];
            hist[1] = rd_now;
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic load_mode(input logic [7:0] w);
        bit len_ok, lat_ok, legal;
        len_ok = (w[2:0] <= 3) || (w[2:0] == 7);
        lat_ok = (w[6:4] >= 1) && (w[6:4] <= 3);
        legal  = len_ok && lat_ok && !((w[2:0] == 7) && w[3]);
        mode_load = 1'b1;
        mode_word = w;
        @(posedge clk);
        if (legal) begin
            m_page   = (w[2:0] == 7);
            m_beats  = m_page ? 256 : (1 << w[2:0]);
            m_inter  = w[3];
            m_cl     = int'(w[6:4]);
            m_single = w[7];
        end
        #1;
        mode_load = 1'b0;
        @(negedge clk);
        check(legal ? "R1" : "R2", int'(mode_err), legal ? 0 : 1, "mode_err pulse");
        @(posedge clk);
        #1;
        check("R2", int'(mode_err), 0, "mode_err one cycle");
    endtask

    task automatic do_cmd(input bit wr, input int col, input bit with_stop);
        int beats, n, mask, base, low;
        bit page;
        cmd_valid  = 1'b1;
        cmd_write  = wr;
        cmd_col    = col[7:0];
        burst_stop = with_stop;
        @(posedge clk);
        q.delete();
        if (wr && m_single) begin
            beats = 1;
            page  = 1'b0;
        end else begin
            beats = m_beats;
            page  = m_page;
        end
        n    = page ? 512 : beats;
        mask = page ? 255 : beats - 1;
        base = col & ~mask & 255;
        for (int k = 0; k < n; k++) begin
            beat_t b;
            low    = m_inter ? (col ^ k) : (col + k);
            b.col  = base | (low & mask);
            b.last = !page && (k == beats - 1);
            b.wr   = wr;
            q.push_back(b);
        end
        #1;
        cmd_valid  = 1'b0;
        burst_stop = 1'b0;
    endtask

    task automatic do_stop();
        burst_stop = 1'b1;
        @(posedge clk);
        q.delete();
        #1;
        burst_stop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1;
        check("R12", int'(col_valid), 0, "reset col_valid");
        check("R12", int'(rd_valid), 0, "reset rd_valid");
        check("R12", int'(mode_err), 0, "reset mode_err");
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        idle(2);
        run = 1'b1;

        cur_tag = "R12";                 // default mode: one beat, latency 2
        do_cmd(1'b0, 5, 1'b0);
        idle(5);

        cur_tag = "R4";                  // length 4, sequential, latency 2
        load_mode(8'b0_010_0_010);
        do_cmd(1'b0, 8'h0E, 1'b0);
        idle(7);

        cur_tag = "R5";                  // length 8, interleaved, latency 3
        load_mode(8'b0_011_1_011);
        do_cmd(1'b0, 8'h35, 1'b0);
        idle(11);

        cur_tag = "R6";                  // length 2, sequential, latency 1
        load_mode(8'b0_001_0_001);
        do_cmd(1'b0, 8'h7F, 1'b0);
        idle(4);

        cur_tag = "R11";                 // writes burst when the option is off
        load_mode(8'b0_010_0_011);
        do_cmd(1'b1, 8'h21, 1'b0);
        idle(10);
        load_mode(8'b1_010_0_011);       // single-beat writes on
        do_cmd(1'b1, 8'h44, 1'b0);
        idle(3);
        do_cmd(1'b0, 8'h44, 1'b0);
        idle(12);

        cur_tag = "R2";                  // reserved words keep length 8 sequential
        load_mode(8'b0_010_0_101);
        load_mode(8'b0_000_0_011);
        load_mode(8'b0_100_0_001);
        load_mode(8'b0_010_1_111);
        do_cmd(1'b0, 8'h93, 1'b0);
        idle(12);

        cur_tag = "R7";                  // full page from near the top
        load_mode(8'b0_010_0_111);
        do_cmd(1'b0, 8'hFE, 1'b0);
        idle(300);
        cur_tag = "R8";
        do_stop();
        idle(4);
        do_stop();                       // stop while idle
        idle(4);

        cur_tag = "R9";                  // back-to-back commands, length 4
        load_mode(8'b0_001_0_010);
        do_cmd(1'b0, 8'h10, 1'b0);
        do_cmd(1'b1, 8'h23, 1'b0);
        do_cmd(1'b0, 8'h37, 1'b0);
        idle(1);
        do_cmd(1'b0, 8'h52, 1'b1);       // R8: command wins over stop
        idle(6);

        cur_tag = "R10";                 // read cut short, data still drains
        load_mode(8'b0_011_0_011);
        do_cmd(1'b0, 8'h60, 1'b0);
        idle(2);
        do_stop();
        idle(6);

        run = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule